// File: doc/BRIEF.md
# Dual-Width Pseudo-Random Noise Generator

This block produces the noise waveform of one sound channel. A programmable period timer counts down in steps of four on every system tick strobe. Each time the timer runs out, it advances a 15-stage linear feedback shift register by one step. The register runs in one of two modes. In long mode its sequence repeats after 32767 steps. In short mode the feedback is also fed into a middle stage, which folds the sequence into a 127-step loop with a more tonal character.

The low stage of the register gates a 4-bit volume onto the amplitude output. The amplitude is forced to zero while the channel is not active or its converter is disabled. One 8-bit control register holds the timer configuration and the width mode, and it reads back exactly as it was written. A trigger strobe restarts the waveform from its seed. The volume, active and converter-enable inputs come from neighbouring channel logic. The amplitude is a continuous level, not a stream of samples, so every pin is plain and no valid/ready handshake or back-pressure applies.

Top module: `noise_lfsr_gen`

## Requirements
- R1: A write (`cfg_we` high for one cycle) stores `cfg_wdata`, and from the next cycle on `cfg_rdata` returns the stored byte unchanged. The control byte is laid out as bits [7:4] rate shift, bit [3] width select (1 = short mode) and bits [2:0] divisor code.
- R2: After reset the control byte reads 0, the timer is 0 and the shift register holds 0x7FFF, so `amp` is 0.
- R3: The timer period is a base value shifted left by the rate shift. The base value is 8 for divisor code 0 and 16 times the code otherwise, giving 8, 16, 32, 48, 64, 80, 96 and 112. On a tick the timer is first loaded with the period if it reads zero. It then loses 4 if it is above 4. Otherwise it is reloaded with the period and the shift register takes one step, so after a restart a step falls on every (period/4)-th tick.
- R4: Without a tick or a trigger, the shift register and the timer hold their values, whatever number of cycles passes.
- R5: A trigger sets the shift register to 0x7FFF and loads the timer with the current period. If a tick arrives in the same cycle, the trigger takes precedence and the tick is dropped.
- R6: `amp` equals `volume` while stage 0 of the shift register is 0, and is 0 while it is 1. It is also 0 whenever `chan_active` or `dac_en` is low. The output is combinational from the register state and these inputs.
- R7: A step computes feedback as stage 0 XOR stage 1, shifts right by one and places the feedback in stage 14. In short mode the same feedback also overwrites stage 6. From the seed, `amp` first turns non-zero after 15 steps in long mode and after 7 steps in short mode.
- R8: A control write changes the period used at the next zero-load, reload or trigger. A count already in progress continues from its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle timer advance strobe |
| trigger | input | 1 | Single-cycle restart strobe |
| cfg_we | input | 1 | Control byte write enable |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read-back |
| volume | input | 4 | Current channel volume |
| chan_active | input | 1 | Channel is sounding |
| dac_en | input | 1 | Channel converter is enabled |
| amp | output | 4 | Noise amplitude |

## Verification
The bench counts the ticks from a restart to the first non-zero amplitude. In long mode this must be 15 steps and in short mode 7 steps, times period/4. A design that decremented by one, swapped the divisor table, ignored the shift or dropped the stage-6 feedback would miss those counts. Triggers that coincide with ticks, ticks spaced with idle gaps, and control writes in the middle of a count catch a design that lets the tick win, advances without a tick, or restarts the count on a write. Lowering the active or converter flag while the waveform sits at full volume exposes a missing output gate.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int unsigned LFSR_W    = 15;
  localparam int unsigned SHORT_TAP = 6;
  localparam int unsigned STEP_DEC  = 4;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  // base divisor: 8 for code 0, otherwise 16 * code
  function automatic int unsigned base_divisor(input int unsigned code);
    return (code == 0) ? 8 : code * 16;
  endfunction

  function automatic int unsigned max_base(input int unsigned div_w);
    return base_divisor((1 << div_w) - 1);
  endfunction
endpackage

// File: rtl/noise_ctrl_reg.sv
module noise_ctrl_reg #(
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned DIV_W   = 3,
  localparam int unsigned CTRL_W = SHIFT_W + 1 + DIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CTRL_W-1:0]  wdata,
  output logic [CTRL_W-1:0]  rdata,
  output logic [SHIFT_W-1:0] shift_amt,
  output logic               short_mode,
  output logic [DIV_W-1:0]   div_code
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  assign rdata      = ctrl_q;
  assign shift_amt  = ctrl_q[CTRL_W-1 -: SHIFT_W];
  assign short_mode = ctrl_q[DIV_W];
  assign div_code   = ctrl_q[DIV_W-1:0];
endmodule

// File: rtl/noise_period_timer.sv
module noise_period_timer
  import noise_pkg::*;
#(
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned DIV_W   = 3,
  localparam int unsigned BASE_W  = $clog2(max_base(DIV_W) + 1),
  localparam int unsigned TIMER_W = BASE_W + (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               trigger,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic [DIV_W-1:0]   div_code,
  output logic               step
);
  localparam int unsigned N_CODES = 1 << DIV_W;

  logic [BASE_W-1:0]  base_tbl [N_CODES];
  logic [TIMER_W-1:0] period;
  logic [TIMER_W-1:0] timer_q;
  logic [TIMER_W-1:0] eff;
  logic               expire;

  for (genvar g = 0; g < N_CODES; g++) begin : g_base
    assign base_tbl[g] = BASE_W'(base_divisor(g));
  end

  assign period = TIMER_W'(base_tbl[div_code]) << shift_amt;
  assign eff    = (timer_q == '0) ? period : timer_q;
  assign expire = (eff <= TIMER_W'(STEP_DEC));
  assign step   = tick && !trigger && expire;

  always_ff @(posedge clk) begin
    if (!rst_n)       timer_q <= '0;
    else if (trigger) timer_q <= period;
    else if (tick)    timer_q <= expire ? period : (eff - TIMER_W'(STEP_DEC));
  end
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              step,
  input  logic              short_mode,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] shifted;
  logic [LFSR_W-1:0] nxt;
  logic              fb;

  assign fb      = state_q[0] ^ state_q[1];
  assign shifted = {fb, state_q[LFSR_W-1:1]};

  for (genvar b = 0; b < LFSR_W; b++) begin : g_bit
    if (b == SHORT_TAP) begin : g_tap
      assign nxt[b] = short_mode ? fb : shifted[b];
    end else begin : g_plain
      assign nxt[b] = shifted[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || seed) state_q <= LFSR_SEED;
    else if (step)      state_q <= nxt;
  end

  assign state = state_q;
endmodule

// File: rtl/noise_amp_gate.sv
module noise_amp_gate #(
  parameter int unsigned VOL_W = 4
) (
  input  logic             noise_bit,
  input  logic             chan_active,
  input  logic             dac_en,
  input  logic [VOL_W-1:0] volume,
  output logic [VOL_W-1:0] amp
);
  always_comb begin
    amp = '0;
    if (chan_active && dac_en && !noise_bit) amp = volume;
  end
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int unsigned SHIFT_W = 4,
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned VOL_W   = 4,
  localparam int unsigned CTRL_W = SHIFT_W + 1 + DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trigger,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic [VOL_W-1:0]  volume,
  input  logic              chan_active,
  input  logic              dac_en,
  output logic [VOL_W-1:0]  amp
);
  logic [SHIFT_W-1:0] shift_amt;
  logic               short_mode;
  logic [DIV_W-1:0]   div_code;
  logic               lfsr_step;
  logic [LFSR_W-1:0]  lfsr_q;

  noise_ctrl_reg #(.SHIFT_W(SHIFT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .shift_amt(shift_amt), .short_mode(short_mode), .div_code(div_code)
  );

  noise_period_timer #(.SHIFT_W(SHIFT_W), .DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
    .shift_amt(shift_amt), .div_code(div_code), .step(lfsr_step)
  );

  noise_lfsr_core u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(trigger), .step(lfsr_step),
    .short_mode(short_mode), .state(lfsr_q)
  );

  noise_amp_gate #(.VOL_W(VOL_W)) u_gate (
    .noise_bit(lfsr_q[0]), .chan_active(chan_active), .dac_en(dac_en),
    .volume(volume), .amp(amp)
  );
endmodule

// File: rtl/noise_checker.sv
module noise_checker
  import noise_pkg::*;
#(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned VOL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              trigger,
  input logic              cfg_we,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic [VOL_W-1:0]  volume,
  input logic              chan_active,
  input logic              dac_en,
  input logic [VOL_W-1:0]  amp,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic              lfsr_step,
  input logic              short_mode
);
  assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trigger) |=> $stable(lfsr_q));

  assert_trigger_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> lfsr_q == LFSR_SEED);

  assert_trigger_blocks_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> !lfsr_step);

  assert_gate_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_active || !dac_en) |-> amp == '0);

  assert_amp_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (amp == '0) || (amp == volume));

  assert_short_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_step && short_mode) |=> lfsr_q[6] == lfsr_q[14]);

  assert_never_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

bind noise_lfsr_gen noise_checker #(.CTRL_W(CTRL_W), .VOL_W(VOL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .volume(volume),
  .chan_active(chan_active), .dac_en(dac_en), .amp(amp), .lfsr_q(lfsr_q),
  .lfsr_step(lfsr_step), .short_mode(short_mode)
);

// File: tb/test_noise_lfsr_gen.sv
module test_noise_lfsr_gen;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0, trigger = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic [3:0] volume = 4'd9;
  logic       chan_active = 1, dac_en = 1;
  logic [3:0] amp;

  int checks = 0, errors = 0;
  int m_lfsr = 32'h7FFF, m_timer = 0, m_ctrl = 0;
  bit done = 0;

  always #10 clk = ~clk;

  noise_lfsr_gen i_noise_lfsr_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .volume(volume),
    .chan_active(chan_active), .dac_en(dac_en), .amp(amp)
  );

  function automatic int period_of(int c);
    int code = c & 7;
    int b = (code == 0) ? 8 : code * 16;
    return b << ((c >> 4) & 15);
  endfunction

  function automatic int lfsr_next(int s, int c);
    int fb = (s & 1) ^ ((s >> 1) & 1);
    int n = (s >> 1) | (fb << 14);
    if (c & 8) n = (n & ~(1 << 6)) | (fb << 6);
    return n;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: model follows the inputs sampled at this edge, compare after
  task automatic cyc();
    int e, p;
    @(posedge clk);
    if (!rst_n) begin
      m_lfsr = 32'h7FFF; m_timer = 0; m_ctrl = 0;
    end else begin
      p = period_of(m_ctrl);
      if (trigger) begin
        m_lfsr = 32'h7FFF; m_timer = p;
      end else if (tick) begin
        e = (m_timer == 0) ? p : m_timer;
        if (e > 4) m_timer = e - 4;
        else begin m_timer = p; m_lfsr = lfsr_next(m_lfsr, m_ctrl); end
      end
      if (cfg_we) m_ctrl = cfg_wdata;
    end
    @(negedge clk);
    check("R6 model amp", amp, (chan_active && dac_en && !(m_lfsr & 1)) ? volume : 0);
    check("R1 model readback", cfg_rdata, m_ctrl);
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; cyc(); cfg_we = 0;
  endtask

  task automatic pulse_trigger(bit with_tick);
    trigger = 1; tick = with_tick; cyc(); trigger = 0; tick = 0;
  endtask

  // ticks until amp first goes non-zero, with 'gap' idle cycles between ticks
  task automatic ticks_to_sound(int gap, output int n);
    n = 0;
    while (amp == 0 && n < 4000) begin
      tick = 1; cyc(); tick = 0; n++;
      for (int i = 0; i < gap; i++) cyc();
    end
  endtask

  initial begin
    int n;
    int seed = 12345;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    check("R2 reset readback", cfg_rdata, 0);
    check("R2 reset amp", amp, 0);

    write_cfg(8'hAB); check("R1 readback AB", cfg_rdata, 8'hAB);
    write_cfg(8'h5C); check("R1 readback 5C", cfg_rdata, 8'h5C);

    write_cfg(8'h00); pulse_trigger(0);
    ticks_to_sound(0, n); check("R3 R7 long mode period 8", n, 15 * 2);
    write_cfg(8'h08); pulse_trigger(0);
    ticks_to_sound(0, n); check("R7 short mode period 8", n, 7 * 2);
    write_cfg(8'h01); pulse_trigger(0);
    ticks_to_sound(0, n); check("R3 divisor code 1", n, 15 * 4);
    write_cfg(8'h10); pulse_trigger(0);
    ticks_to_sound(0, n); check("R3 shift 1", n, 15 * 4);
    write_cfg(8'h1B); pulse_trigger(0);
    ticks_to_sound(0, n); check("R3 R7 short div3 shift1", n, 7 * 24);

    // gating while sounding
    chan_active = 0; #1; check("R6 inactive silences", amp, 0);
    chan_active = 1; #1; check("R6 active restores", amp, 9);
    dac_en = 0; #1; check("R6 converter off silences", amp, 0);
    dac_en = 1; volume = 4'd5; #1; check("R6 follows volume", amp, 5);

    // idle gaps between ticks do not advance anything
    write_cfg(8'h00); pulse_trigger(0);
    ticks_to_sound(3, n); check("R4 sparse ticks", n, 30);
    repeat (20) cyc(); check("R4 idle hold amp", amp, 5);

    // trigger with simultaneous tick: tick dropped
    pulse_trigger(1); check("R5 trigger reseeds", amp, 0);
    ticks_to_sound(0, n); check("R5 trigger beats tick", n, 30);

    // mid-count write: count continues from current value (period 16 -> 8)
    write_cfg(8'h01); pulse_trigger(0);
    tick = 1; cyc(); cyc(); tick = 0;   // timer 16 -> 12 -> 8
    write_cfg(8'h00);                   // period now 8
    ticks_to_sound(0, n); check("R8 mid-count write", n, 2 + 14 * 2);

    // mixed stimulus against the model
    for (int k = 0; k < 3000; k++) begin
      seed = seed * 1103515245 + 12345;
      tick = seed[16]; trigger = (seed[23:18] == 0);
      cfg_we = (seed[29:25] == 0); cfg_wdata = seed[7:0] & 8'hCF;
      chan_active = (seed[12:10] != 0); dac_en = (seed[15:13] != 0);
      volume = seed[11:8];
      cyc();
    end
    tick = 0; trigger = 0; cfg_we = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule